// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a 40-bit physical address by fetching up to two 32-bit entries from an in-memory translation hierarchy. A walk begins when the requester raises a start strobe while the walker is idle. The walker reads a directory entry first. That entry either maps a 4 MiB page directly or points to a 4 KiB table, from which a second entry is read to map a 4 KiB page.

Three mode inputs shape each walk, and they are captured when the request is taken. Large-page enable decides whether directory bit 7 marks a direct mapping. Extended-36 support widens large-page addresses above 4 GiB. Attribute-table support frees bits that would otherwise be reserved. A physical-width parameter sets which large-page bits are reserved.

The walk stops at the first entry that is not present or that has a reserved bit set, and reports a fault. Otherwise it reports the physical address and whether the page is large. Memory is reached through a one-cycle read request and a later data-valid strobe.

Top module: `xlat_walker`

## Requirements
- R1: The directory read address is {8'h00, dir_base[31:12], walk_lin[31:22], 2'b00}.
- R2: A present directory entry maps a large page only when large pages are enabled and entry bit 7 is 1. In every other case it is treated as a table pointer and a second read is made.
- R3: A large page yields walk_pa = {dir[20:13], dir[31:22], walk_lin[21:0]} with walk_big = 1.
- R4: The table read address is {8'h00, dir[31:12], walk_lin[21:12], 2'b00}.
- R5: A 4 KiB page yields walk_pa = {8'h00, tbl[31:12], walk_lin[11:0]} with walk_big = 0.
- R6: An entry whose bit 0 is 0 ends the walk with a fault, and no further read is issued.
- R7: With large pages disabled, no entry bit is reserved. Directory bits 21:13 and 7, and table bit 7, cause no fault.
- R8: The reserved bits of a present large-page directory entry depend on extended-36 support. Without it, bits 21:13 are reserved. With it, bits 21 down to (M-19) are reserved, where M = min(40, PHYS_BITS); at the default of 40 that is bit 21 alone. A set reserved bit causes a fault.
- R9: When large pages are enabled and attribute-table support is off, two further bits are reserved: bit 12 of a present large-page directory entry, and bit 7 of a present table entry. With attribute-table support on, both bits are free.
- R10: Each level issues exactly one rd_req, lasting one cycle. rd_addr holds steady until rd_valid returns.
- R11: walk_done pulses for one cycle. It comes with walk_fault = 1, walk_pa = 0 and walk_big = 0 on a fault, or with walk_fault = 0 and a valid address otherwise. walk_idle is 0 during a walk, and a start seen while busy is ignored.
- R12: The linear address, base and mode inputs are captured when the request is accepted. Changes to them during a walk have no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_start | input | 1 | Request a walk; taken only while idle |
| walk_lin | input | 32 | Linear address to translate |
| dir_base | input | 32 | Directory base register; bits 31:12 used |
| big_pg_en | input | 1 | Large-page enable |
| ext36_en | input | 1 | Extended-36 large-page addressing supported |
| attr_en | input | 1 | Attribute-table supported |
| walk_idle | output | 1 | Walker can accept a request |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | 40 | Memory read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data (entry) |
| walk_done | output | 1 | Walk finished (one cycle) |
| walk_fault | output | 1 | Walk ended in a page fault |
| walk_pa | output | 40 | Translated physical address |
| walk_big | output | 1 | Result is a 4 MiB page |

## Verification
Completion of one walk and acceptance of the next can happen in the same cycle. walk_done rises as the walker returns to idle, so a start held high in that cycle begins a new walk at once. The bench keeps walk_start high through the first walk and swaps the linear address exactly at the done cycle. It then checks that the first result reflects the old address and the second the new one. It also checks that the read count matches two walks, with no read lost or duplicated at the handover.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int LIN_W   = 32;
  localparam int ENT_W   = 32;
  localparam int PA_W    = 40;
  localparam int PA_CAP  = 40;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_TREQ, ST_TWAIT
  } walk_st_e;

  function automatic int eff_width(int phys);
    return (phys < PA_CAP) ? phys : PA_CAP;
  endfunction

  function automatic logic [PA_W-1:0] dir_addr(logic [LIN_W-1:0] base, logic [LIN_W-1:0] lin);
    return {8'h00, base[31:12], lin[31:22], 2'b00};
  endfunction

  function automatic logic [PA_W-1:0] tbl_addr(logic [ENT_W-1:0] pde, logic [LIN_W-1:0] lin);
    return {8'h00, pde[31:12], lin[21:12], 2'b00};
  endfunction

  function automatic logic [PA_W-1:0] big_pa(logic [ENT_W-1:0] pde, logic [LIN_W-1:0] lin);
    return {pde[20:13], pde[31:22], lin[21:0]};
  endfunction

  function automatic logic [PA_W-1:0] small_pa(logic [ENT_W-1:0] pte, logic [LIN_W-1:0] lin);
    return {8'h00, pte[31:12], lin[11:0]};
  endfunction

  // Reserved bits of a present large-page directory entry.
  function automatic logic [ENT_W-1:0] dir_rsvd_mask(logic ext36, logic attr, int m);
    logic [ENT_W-1:0] mk;
    mk = '0;
    for (int i = 13; i <= 21; i++) begin
      if (!ext36 || (i >= m - 19)) mk[i] = 1'b1;
    end
    if (!attr) mk[12] = 1'b1;
    return mk;
  endfunction

endpackage

// File: rtl/xlat_rsvd_check.sv
module xlat_rsvd_check
  import xlat_pkg::*;
#(
  parameter int PHYS_BITS = 40
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             at_dir,
  input  logic             big_en,
  input  logic             ext36,
  input  logic             attr,
  output logic             present,
  output logic             is_leaf,
  output logic             rsvd_hit
);
  localparam int EFF_M = (PHYS_BITS < PA_CAP) ? PHYS_BITS : PA_CAP;

  assign present = entry[0];
  assign is_leaf = at_dir && big_en && entry[7];

  always_comb begin
    rsvd_hit = 1'b0;
    if (present && big_en) begin
      if (at_dir) begin
        if (entry[7]) rsvd_hit = |(entry & dir_rsvd_mask(ext36, attr, EFF_M));
      end else begin
        rsvd_hit = !attr && entry[7];
      end
    end
  end

  always_comb begin
    if (!big_en) begin
      AST_FLAT_NO_RSVD: assert (!rsvd_hit && !is_leaf); // R7
    end
  end

endmodule

// File: rtl/xlat_walk_fsm.sv
module xlat_walk_fsm
  import xlat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     rd_valid,
  input  logic     present,
  input  logic     is_leaf,
  input  logic     rsvd_hit,
  output walk_st_e state,
  output logic     accept,
  output logic     dir_eval,
  output logic     fin,
  output logic     fin_fault,
  output logic     fin_big
);
  walk_st_e nxt;
  logic     tbl_eval;
  logic     bad;

  assign accept    = start && (state == ST_IDLE);
  assign dir_eval  = (state == ST_DWAIT) && rd_valid;
  assign tbl_eval  = (state == ST_TWAIT) && rd_valid;
  assign bad       = !present || rsvd_hit;
  assign fin       = (dir_eval && (bad || is_leaf)) || tbl_eval;
  assign fin_fault = fin && bad;
  assign fin_big   = dir_eval && !bad && is_leaf;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = ST_DREQ;
      ST_DREQ:  nxt = ST_DWAIT;
      ST_DWAIT: if (rd_valid) nxt = (bad || is_leaf) ? ST_IDLE : ST_TREQ;
      ST_TREQ:  nxt = ST_TWAIT;
      ST_TWAIT: if (rd_valid) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_ABSENT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DWAIT && rd_valid && !present) |=> (state == ST_IDLE)); // R6

  AST_TABLE_AFTER_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DWAIT && rd_valid && present && !is_leaf) |=> (state == ST_TREQ)); // R2

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int PHYS_BITS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_start,
  input  logic [LIN_W-1:0] walk_lin,
  input  logic [LIN_W-1:0] dir_base,
  input  logic             big_pg_en,
  input  logic             ext36_en,
  input  logic             attr_en,
  output logic             walk_idle,
  output logic             rd_req,
  output logic [PA_W-1:0]  rd_addr,
  input  logic             rd_valid,
  input  logic [ENT_W-1:0] rd_data,
  output logic             walk_done,
  output logic             walk_fault,
  output logic [PA_W-1:0]  walk_pa,
  output logic             walk_big
);
  walk_st_e         state;
  logic             accept, dir_eval, fin, fin_fault, fin_big;
  logic             present, is_leaf, rsvd_hit, at_dir;
  logic [LIN_W-1:0] lin_q;
  logic [19:0]      base_q;
  logic [19:0]      ptr_q;
  logic             big_q, e36_q, attr_q;

  assign at_dir    = (state == ST_DWAIT);
  assign walk_idle = (state == ST_IDLE);
  assign rd_req    = (state == ST_DREQ) || (state == ST_TREQ);
  assign rd_addr   = ((state == ST_DREQ) || (state == ST_DWAIT))
                   ? dir_addr({base_q, 12'h000}, lin_q)
                   : tbl_addr({ptr_q, 12'h000}, lin_q);

  xlat_rsvd_check #(.PHYS_BITS(PHYS_BITS)) u_chk (
    .entry(rd_data), .at_dir(at_dir), .big_en(big_q), .ext36(e36_q),
    .attr(attr_q), .present(present), .is_leaf(is_leaf), .rsvd_hit(rsvd_hit)
  );

  xlat_walk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .rd_valid(rd_valid),
    .present(present), .is_leaf(is_leaf), .rsvd_hit(rsvd_hit),
    .state(state), .accept(accept), .dir_eval(dir_eval), .fin(fin),
    .fin_fault(fin_fault), .fin_big(fin_big)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_q  <= '0;
      base_q <= '0;
      big_q  <= 1'b0;
      e36_q  <= 1'b0;
      attr_q <= 1'b0;
    end else if (accept) begin
      lin_q  <= walk_lin;
      base_q <= dir_base[31:12];
      big_q  <= big_pg_en;
      e36_q  <= ext36_en;
      attr_q <= attr_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr_q <= '0;
    else if (dir_eval) ptr_q <= rd_data[31:12];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walk_done  <= 1'b0;
      walk_fault <= 1'b0;
      walk_pa    <= '0;
      walk_big   <= 1'b0;
    end else begin
      walk_done <= fin;
      if (fin) begin
        walk_fault <= fin_fault;
        walk_big   <= fin_big;
        if (fin_fault)   walk_pa <= '0;
        else if (at_dir) walk_pa <= big_pa(rd_data, lin_q);
        else             walk_pa <= small_pa(rd_data, lin_q);
      end
    end
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R10

  AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DWAIT || state == ST_TWAIT) |-> $stable(rd_addr)); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done); // R11

  AST_FAULT_CLEARS_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault) |-> (walk_pa == '0 && !walk_big)); // R11

  AST_SMALL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && !walk_fault && !walk_big) |-> (walk_pa[39:32] == 8'h00)); // R5

  AST_BIG_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_big) |-> (walk_pa[21:0] == lin_q[21:0])); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!walk_idle && $past(!walk_idle)) |-> ($stable(lin_q) && $stable(big_q))); // R12

endmodule

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_start = 1'b0;
  logic [31:0] walk_lin = '0;
  logic [31:0] dir_base = '0;
  logic        big_pg_en = 1'b0, ext36_en = 1'b0, attr_en = 1'b0;
  logic        walk_idle, rd_req, rd_valid = 1'b0;
  logic [39:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic        walk_done, walk_fault, walk_big;
  logic [39:0] walk_pa;

  int n_chk = 0, n_bad = 0;
  int nreads = 0;
  logic [39:0] log_addr [4];
  logic [31:0] mem [logic [39:0]];

  logic        r_fault, r_big;
  logic [39:0] r_pa;

  always #2.5 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .walk_lin(walk_lin),
    .dir_base(dir_base), .big_pg_en(big_pg_en), .ext36_en(ext36_en),
    .attr_en(attr_en), .walk_idle(walk_idle), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .walk_done(walk_done), .walk_fault(walk_fault), .walk_pa(walk_pa),
    .walk_big(walk_big)
  );

  // memory responder: two-cycle latency
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        if (nreads < 4) log_addr[nreads] = rd_addr;
        nreads++;
        rd_data = mem.exists(rd_addr) ? mem[rd_addr] : 32'h0;
        repeat (2) @(negedge clk);
        rd_valid = 1'b1;
      end
    end
  end

  function automatic logic [39:0] x_dir(logic [31:0] b, logic [31:0] l);
    return 40'((b & 32'hFFFF_F000) | ((l >> 22) << 2));
  endfunction
  function automatic logic [39:0] x_tbl(logic [31:0] p, logic [31:0] l);
    return 40'((p & 32'hFFFF_F000) | (((l >> 12) & 32'h3FF) << 2));
  endfunction
  function automatic logic [39:0] x_big(logic [31:0] p, logic [31:0] l);
    return (40'((p >> 13) & 32'hFF) << 32) | 40'(p & 32'hFFC0_0000) | 40'(l & 32'h003F_FFFF);
  endfunction
  function automatic logic [39:0] x_small(logic [31:0] p, logic [31:0] l);
    return 40'((p & 32'hFFFF_F000) | (l & 32'hFFF));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic wait_done(string req);
    int k = 0;
    while (!walk_done && k < 60) begin
      @(negedge clk);
      k++;
    end
    if (!walk_done) chk(req, 64'd0, 64'd1);
    r_fault = walk_fault;
    r_big   = walk_big;
    r_pa    = walk_pa;
  endtask

  task automatic launch(logic [31:0] lin, logic [31:0] base, logic bg, logic e36, logic at);
    @(negedge clk);
    nreads = 0;
    walk_lin = lin; dir_base = base;
    big_pg_en = bg; ext36_en = e36; attr_en = at;
    walk_start = 1'b1;
    @(negedge clk);
    walk_start = 1'b0;
  endtask

  task automatic walk(logic [31:0] lin, logic [31:0] base, logic bg, logic e36, logic at, string req);
    launch(lin, base, bg, e36, at);
    wait_done(req);
    @(negedge clk);
  endtask

  localparam logic [31:0] BASE = 32'h0012_3ABC;

  task automatic t_reset();
    chk("R11 idle after reset", 64'(walk_idle), 64'd1);
    chk("R11 done low after reset", 64'(walk_done), 64'd0);
    chk("R10 no read after reset", 64'(rd_req), 64'd0);
  endtask

  task automatic t_small();
    logic [31:0] lin = 32'hABCD_E123, pde = 32'h0045_6007, pte = 32'h789A_B003;
    mem[x_dir(BASE, lin)] = pde;
    mem[x_tbl(pde, lin)]  = pte;
    walk(lin, BASE, 1'b1, 1'b1, 1'b1, "R5");
    chk("R1 dir address", 64'(log_addr[0]), 64'(x_dir(BASE, lin)));
    chk("R4 table address", 64'(log_addr[1]), 64'(x_tbl(pde, lin)));
    chk("R10 two reads", 64'(nreads), 64'd2);
    chk("R5 small pa", 64'(r_pa), 64'(x_small(pte, lin)));
    chk("R5 small flag/fault", 64'({r_big, r_fault}), 64'd0);
  endtask

  task automatic t_big();
    logic [31:0] lin = 32'h1234_5678;
    logic [31:0] pde = (32'h2A5 << 22) | (32'hC3 << 13) | (32'h1 << 12) | 32'h81;
    mem[x_dir(BASE, lin)] = pde;
    walk(lin, BASE, 1'b1, 1'b1, 1'b1, "R3");
    chk("R2 big one read", 64'(nreads), 64'd1);
    chk("R3 big pa", 64'(r_pa), 64'(x_big(pde, lin)));
    chk("R3 big flag", 64'({r_big, r_fault}), 64'b10);
  endtask

  task automatic t_flat();
    logic [31:0] lin = 32'h0800_1ABC, pde = 32'h0FFF_F081 | 32'h003F_F000, pte = 32'h5555_5081;
    mem[x_dir(BASE, lin)] = pde;
    mem[x_tbl(pde, lin)]  = pte;
    walk(lin, BASE, 1'b0, 1'b0, 1'b0, "R7");
    chk("R2 bit7 ignored when disabled", 64'(nreads), 64'd2);
    chk("R7 no reserved when disabled", 64'(r_fault), 64'd0);
    chk("R7 small pa", 64'(r_pa), 64'(x_small(pte, lin)));
  endtask

  task automatic t_absent();
    logic [31:0] lin = 32'h4000_0000, lin2 = 32'h4400_3000;
    mem[x_dir(BASE, lin)] = 32'hFFFF_FFFE;
    walk(lin, BASE, 1'b1, 1'b0, 1'b0, "R6");
    chk("R6 absent dir fault", 64'({r_fault, r_big}), 64'b10);
    chk("R6 absent dir one read", 64'(nreads), 64'd1);
    chk("R11 fault pa zero", 64'(r_pa), 64'd0);
    mem[x_dir(BASE, lin2)] = 32'h0066_6001;
    mem[x_tbl(32'h0066_6001, lin2)] = 32'h1234_5000;
    walk(lin2, BASE, 1'b1, 1'b1, 1'b1, "R6");
    chk("R6 absent table fault", 64'(r_fault), 64'd1);
    chk("R6 absent table two reads", 64'(nreads), 64'd2);
  endtask

  task automatic t_rsvd();
    logic [31:0] la = 32'h8000_0000, lb = 32'h8400_0000, lc = 32'h8800_0000, ld = 32'h8C00_0000;
    logic [31:0] pa_ = (32'h3 << 22) | (32'h1 << 13) | 32'h81;
    logic [31:0] pb_ = (32'h3 << 22) | (32'h1 << 21) | 32'h81;
    logic [31:0] pc_ = (32'h3 << 22) | (32'h1 << 12) | 32'h81;
    logic [31:0] pd_ = 32'h0077_7001;
    mem[x_dir(BASE, la)] = pa_;
    mem[x_dir(BASE, lb)] = pb_;
    mem[x_dir(BASE, lc)] = pc_;
    mem[x_dir(BASE, ld)] = pd_;
    mem[x_tbl(pd_, ld)]  = 32'h2222_2081;
    walk(la, BASE, 1'b1, 1'b0, 1'b1, "R8");
    chk("R8 bit13 reserved without ext36", 64'(r_fault), 64'd1);
    walk(la, BASE, 1'b1, 1'b1, 1'b1, "R8");
    chk("R8 bit13 free with ext36", 64'({r_fault, r_big}), 64'b01);
    chk("R8 bit13 lands in pa bit32", 64'(r_pa), 64'(x_big(pa_, la)));
    walk(lb, BASE, 1'b1, 1'b1, 1'b1, "R8");
    chk("R8 bit21 reserved with ext36", 64'(r_fault), 64'd1);
    walk(lc, BASE, 1'b1, 1'b1, 1'b0, "R9");
    chk("R9 dir bit12 reserved no attr", 64'(r_fault), 64'd1);
    walk(lc, BASE, 1'b1, 1'b1, 1'b1, "R9");
    chk("R9 dir bit12 free with attr", 64'(r_fault), 64'd0);
    walk(ld, BASE, 1'b1, 1'b1, 1'b0, "R9");
    chk("R9 table bit7 reserved no attr", 64'(r_fault), 64'd1);
    walk(ld, BASE, 1'b1, 1'b1, 1'b1, "R9");
    chk("R9 table bit7 free with attr", 64'(r_fault), 64'd0);
  endtask

  task automatic t_latch();
    logic [31:0] lin = 32'hC000_1234, other = 32'h0040_0000;
    logic [31:0] pde = (32'h155 << 22) | 32'h81;
    mem[x_dir(BASE, lin)] = pde;
    launch(lin, BASE, 1'b1, 1'b1, 1'b1);
    walk_lin = other; dir_base = 32'h0999_9000; big_pg_en = 1'b0; attr_en = 1'b0;
    wait_done("R12");
    @(negedge clk);
    chk("R12 latched address used", 64'(log_addr[0]), 64'(x_dir(BASE, lin)));
    chk("R12 latched mode used", 64'({r_big, r_fault}), 64'b10);
    chk("R12 latched pa", 64'(r_pa), 64'(x_big(pde, lin)));
  endtask

  task automatic t_busy();
    logic [31:0] lin = 32'hABCD_E123;
    int dones = 0;
    launch(lin, BASE, 1'b1, 1'b1, 1'b1);
    chk("R11 busy during walk", 64'(walk_idle), 64'd0);
    walk_lin = 32'h1234_5678; walk_start = 1'b1;
    @(negedge clk);
    walk_start = 1'b0;
    for (int c = 0; c < 30; c++) begin
      if (walk_done) dones++;
      @(negedge clk);
    end
    chk("R11 start while busy ignored reads", 64'(nreads), 64'd2);
    chk("R11 single done", 64'(dones), 64'd1);
  endtask

  task automatic t_b2b();
    logic [31:0] la = 32'hABCD_E123, lb = 32'h1234_5678;
    logic [39:0] pa1;
    @(negedge clk);
    nreads = 0;
    walk_lin = la; dir_base = BASE; big_pg_en = 1'b1; ext36_en = 1'b1; attr_en = 1'b1;
    walk_start = 1'b1;
    @(negedge clk);
    wait_done("R11");
    pa1 = r_pa;
    walk_lin = lb;
    @(negedge clk);
    walk_start = 1'b0;
    wait_done("R11");
    @(negedge clk);
    chk("R11 first of back-to-back", 64'(pa1), 64'(x_small(32'h789A_B003, la)));
    chk("R11 second of back-to-back", 64'(r_pa), 64'(x_big(mem[x_dir(BASE, lb)], lb)));
    chk("R10 back-to-back read count", 64'(nreads), 64'd3);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_big();
    t_flat();
    t_absent();
    t_rsvd();
    t_latch();
    t_busy();
    t_b2b();
    summary();
    $finish;
  end

endmodule